// File: doc/BRIEF.md
# Special Bus Cycle Decoder

This block sits on the system side of a 64-bit processor bus and watches every cycle that the processor starts with its address strobe. When the cycle-definition lines mark the cycle as special (data/code low, memory/IO low, write/read high), the block works out which special cycle it is from the byte-enable lines and the upper address bits alone. It then answers the cycle with a ready pulse and raises a one-clock flag that other system logic (power management, cache control, debug) can act upon. Memory and I/O cycles are left to the rest of the system. For them this block stays silent.

One special cycle, the branch-trace message, spans two transfers. In both transfers the low 32 data lines carry a valid instruction pointer, although the byte enables would suggest otherwise. The block answers both transfers and captures the source pointer from the first and the target pointer from the second. Once both halves are held, it presents the pair with a one-clock valid pulse.

Top module: `sbc_decoder`

## Requirements
- R1: A cycle is special only when the strobe is high together with data/code = 0, memory/IO = 0 and write/read = 1, sampled at a rising clock edge while the ready output is low. Such a cycle raises the ready output in the very next clock.
- R2: The type output is one-hot with this bit assignment: bit 0 shutdown (BE FEh, byte address 00h), bit 1 cache invalidation (BE FDh, 00h), bit 2 stop grant (BE FBh, 10h), bit 3 halt (BE FBh, 00h), bit 4 writeback-and-invalidate (BE F7h, 00h), bit 5 flush acknowledge (BE EFh, 00h), bit 6 branch-trace message (BE DFh, 00h). The byte address is formed from address bits 31..3 with bits 2..0 taken as zero.
- R3: Stop grant and halt share BE FBh and are told apart only by the address field. A byte address of 10h gives bit 2, 00h gives bit 3, and any other address with FBh gives bit 7.
- R4: A special cycle whose byte-enable and address pair is not in the R2 map sets type bit 7 (unknown) and is still answered with ready.
- R5: A strobed cycle that is not special, or a special definition with the strobe low, produces no type bit and no ready.
- R6: For every accepted special cycle exactly one type bit is high, and only for the clock in which the first ready is high.
- R7: A branch-trace message holds ready high for two consecutive clocks. The type bit 6 is set only in the first of them. Every other special cycle gives a single ready clock.
- R8: The source pointer is taken from data bits 31..0 at the end of the first ready clock of a branch-trace message, and the target pointer at the end of the second. The trace valid output pulses for one clock right after the second ready clock. Both pointers hold until the next message or reset.
- R9: A strobe that arrives while the ready output is high is ignored. It produces no flag and no extra ready.
- R10: A synchronous active-high reset clears ready, the type flags, the trace valid pulse, both captured pointers and the two-transfer sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ads_i | input | 1 | Address strobe, marks the first clock of a bus cycle |
| dc_i | input | 1 | Data/code cycle-definition line |
| mio_i | input | 1 | Memory/IO cycle-definition line |
| wr_i | input | 1 | Write/read cycle-definition line |
| be_i | input | 8 | Byte enables, used here as a special-cycle code |
| addr_i | input | 29 | Address bits 31..3 |
| data_i | input | 32 | Low 32 data lines, read during branch-trace transfers |
| rdy_o | output | 1 | Ready response to special cycles |
| type_o | output | 8 | One-hot special-cycle type flags, bit 7 = unknown |
| trace_valid_o | output | 1 | One-clock pulse when a branch-trace pointer pair is complete |
| trace_src_o | output | 32 | Captured branch source pointer |
| trace_tgt_o | output | 32 | Captured branch target pointer |

## Verification
The checker watches on every clock that a special cycle accepted at the strobe is answered with ready one clock later. It also checks that the type flags are never more than one-hot and appear only together with ready, and that idle clocks with no special strobe keep ready low. The branch-trace ordering is checked each clock as well: a second capture always follows the first directly, and the valid pulse follows a ready clock and does not overlap one. Only the directed scenarios can show that each byte-enable and address pair lands on the right flag, that the stop-grant and halt split rests on the address, and that the exact data words end up in the source and target outputs. The same holds for strobes ignored during ready and for reset wiping the captured pair.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int NKNOWN = 7;
  localparam int NTYPES = NKNOWN + 1;

  localparam int IDX_SHUTDOWN = 0;
  localparam int IDX_INVAL    = 1;
  localparam int IDX_STOPGNT  = 2;
  localparam int IDX_HALT     = 3;
  localparam int IDX_WBINVAL  = 4;
  localparam int IDX_FLUSHACK = 5;
  localparam int IDX_BTRACE   = 6;
  localparam int IDX_UNKNOWN  = 7;

  // byte-enable code for each known special cycle
  function automatic logic [7:0] map_be(input int idx);
    case (idx)
      IDX_SHUTDOWN: map_be = 8'hFE;
      IDX_INVAL:    map_be = 8'hFD;
      IDX_STOPGNT:  map_be = 8'hFB;
      IDX_HALT:     map_be = 8'hFB;
      IDX_WBINVAL:  map_be = 8'hF7;
      IDX_FLUSHACK: map_be = 8'hEF;
      IDX_BTRACE:   map_be = 8'hDF;
      default:      map_be = 8'hFF;
    endcase
  endfunction

  // byte address that goes with each byte-enable code
  function automatic logic [31:0] map_addr(input int idx);
    case (idx)
      IDX_STOPGNT: map_addr = 32'h0000_0010;
      default:     map_addr = 32'h0000_0000;
    endcase
  endfunction

  // cycle-definition combination shared by all special cycles
  function automatic logic is_special(input logic dc, input logic mio, input logic wr);
    return !dc && !mio && wr;
  endfunction

endpackage

// File: rtl/sbc_classify.sv
module sbc_classify
  import sbc_pkg::*;
#(
  parameter int BE_W    = 8,
  parameter int ADDR_HI = 31,
  parameter int ADDR_LO = 3
) (
  input  logic                       special_i,
  input  logic [BE_W-1:0]            be_i,
  input  logic [ADDR_HI:ADDR_LO]     addr_i,
  output logic [NTYPES-1:0]          kind_o
);

  logic [NKNOWN-1:0] hit;

  for (genvar g = 0; g < NKNOWN; g++) begin : g_entry
    localparam logic [7:0]  BEV = map_be(g);
    localparam logic [31:0] AV  = map_addr(g);
    assign hit[g] = (be_i == BEV[BE_W-1:0]) && (addr_i == AV[ADDR_HI:ADDR_LO]);
  end

  always_comb begin
    kind_o = '0;
    if (special_i) begin
      kind_o[NKNOWN-1:0]  = hit;
      kind_o[IDX_UNKNOWN] = ~|hit;
    end
  end

endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
  import sbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ads_i,
  input  logic              special_i,
  input  logic [NTYPES-1:0] kind_i,
  output logic              rdy_o,
  output logic [NTYPES-1:0] type_o,
  output logic              accept_o,
  output logic              cap_src_o,
  output logic              cap_tgt_o
);

  logic              rdy_q;
  logic [NTYPES-1:0] type_q;
  logic              second_q;

  assign accept_o  = ads_i && special_i && !rdy_q;
  assign cap_src_o = rdy_q && type_q[IDX_BTRACE];
  assign cap_tgt_o = second_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q    <= 1'b0;
      type_q   <= '0;
      second_q <= 1'b0;
    end else begin
      rdy_q    <= accept_o || cap_src_o;
      type_q   <= accept_o ? kind_i : '0;
      second_q <= cap_src_o;
    end
  end

  assign rdy_o  = rdy_q;
  assign type_o = type_q;

endmodule

// File: rtl/sbc_capture.sv
module sbc_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_src_i,
  input  logic              cap_tgt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] src_o,
  output logic [DATA_W-1:0] tgt_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_o   <= '0;
      tgt_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      if (cap_src_i) src_o <= data_i;
      if (cap_tgt_i) tgt_o <= data_i;
      valid_o <= cap_tgt_i;
    end
  end

endmodule

// File: rtl/sbc_decoder.sv
module sbc_decoder
  import sbc_pkg::*;
#(
  parameter int BE_W    = 8,
  parameter int ADDR_HI = 31,
  parameter int ADDR_LO = 3,
  parameter int DATA_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ads_i,
  input  logic                   dc_i,
  input  logic                   mio_i,
  input  logic                   wr_i,
  input  logic [BE_W-1:0]        be_i,
  input  logic [ADDR_HI:ADDR_LO] addr_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic                   rdy_o,
  output logic [NTYPES-1:0]      type_o,
  output logic                   trace_valid_o,
  output logic [DATA_W-1:0]      trace_src_o,
  output logic [DATA_W-1:0]      trace_tgt_o
);

  logic              special;
  logic [NTYPES-1:0] kind;
  logic              accept;
  logic              cap_src;
  logic              cap_tgt;

  assign special = is_special(dc_i, mio_i, wr_i);

  sbc_classify #(
    .BE_W    (BE_W),
    .ADDR_HI (ADDR_HI),
    .ADDR_LO (ADDR_LO)
  ) classify_i (
    .special_i (special),
    .be_i      (be_i),
    .addr_i    (addr_i),
    .kind_o    (kind)
  );

  sbc_seq seq_i (
    .clk       (clk),
    .rst       (rst),
    .ads_i     (ads_i),
    .special_i (special),
    .kind_i    (kind),
    .rdy_o     (rdy_o),
    .type_o    (type_o),
    .accept_o  (accept),
    .cap_src_o (cap_src),
    .cap_tgt_o (cap_tgt)
  );

  sbc_capture #(
    .DATA_W (DATA_W)
  ) capture_i (
    .clk       (clk),
    .rst       (rst),
    .cap_src_i (cap_src),
    .cap_tgt_i (cap_tgt),
    .data_i    (data_i),
    .valid_o   (trace_valid_o),
    .src_o     (trace_src_o),
    .tgt_o     (trace_tgt_o)
  );

endmodule

// File: rtl/sbc_decoder_chk.sv
module sbc_decoder_chk
  import sbc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ads_i,
  input logic              dc_i,
  input logic              mio_i,
  input logic              wr_i,
  input logic              rdy_o,
  input logic [NTYPES-1:0] type_o,
  input logic              trace_valid_o,
  input logic              accept,
  input logic              cap_src,
  input logic              cap_tgt
);

  logic strobe_special;
  assign strobe_special = ads_i && !dc_i && !mio_i && wr_i;

  assert_accept_ready_R1: assert property (@(posedge clk) disable iff (rst)
    accept |=> rdy_o);

  assert_idle_stays_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!rdy_o && !strobe_special) |=> (!rdy_o && type_o == '0));

  assert_flags_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(type_o));

  assert_flag_with_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (type_o != '0) |-> rdy_o);

  assert_trace_two_ready_R7: assert property (@(posedge clk) disable iff (rst)
    type_o[IDX_BTRACE] |=> (rdy_o && type_o == '0));

  assert_target_after_source_R8: assert property (@(posedge clk) disable iff (rst)
    cap_tgt |-> $past(cap_src));

  assert_valid_after_ready_R8: assert property (@(posedge clk) disable iff (rst)
    trace_valid_o |-> (!rdy_o && $past(rdy_o)));

  assert_busy_strobe_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && strobe_special) |-> !accept);

endmodule

bind sbc_decoder sbc_decoder_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .ads_i         (ads_i),
  .dc_i          (dc_i),
  .mio_i         (mio_i),
  .wr_i          (wr_i),
  .rdy_o         (rdy_o),
  .type_o        (type_o),
  .trace_valid_o (trace_valid_o),
  .accept        (accept),
  .cap_src       (cap_src),
  .cap_tgt       (cap_tgt)
);

// File: tb/sbc_decoder_tb_top.sv
`timescale 1ns/1ps
module sbc_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ads_i = 1'b0;
  logic        dc_i = 1'b1;
  logic        mio_i = 1'b1;
  logic        wr_i = 1'b0;
  logic [7:0]  be_i = 8'hFF;
  logic [31:3] addr_i = '0;
  logic [31:0] data_i = '0;
  logic        rdy_o;
  logic [7:0]  type_o;
  logic        trace_valid_o;
  logic [31:0] trace_src_o;
  logic [31:0] trace_tgt_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sbc_decoder dut_i (
    .clk           (clk),
    .rst           (rst),
    .ads_i         (ads_i),
    .dc_i          (dc_i),
    .mio_i         (mio_i),
    .wr_i          (wr_i),
    .be_i          (be_i),
    .addr_i        (addr_i),
    .data_i        (data_i),
    .rdy_o         (rdy_o),
    .type_o        (type_o),
    .trace_valid_o (trace_valid_o),
    .trace_src_o   (trace_src_o),
    .trace_tgt_o   (trace_tgt_o)
  );

  // expected one-hot flag from the requirement map
  function automatic logic [7:0] expect_type(input logic [7:0] be, input logic [31:0] baddr);
    logic [7:0] r;
    r = 8'h80;
    if (baddr == 32'h0) begin
      case (be)
        8'hFE: r = 8'h01;
        8'hFD: r = 8'h02;
        8'hFB: r = 8'h08;
        8'hF7: r = 8'h10;
        8'hEF: r = 8'h20;
        8'hDF: r = 8'h40;
        default: r = 8'h80;
      endcase
    end else if (baddr == 32'h10 && be == 8'hFB) begin
      r = 8'h04;
    end
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    ads_i = 1'b0; dc_i = 1'b1; mio_i = 1'b1; wr_i = 1'b0; be_i = 8'hFF; addr_i = '0;
  endtask

  // present one strobe at the current negedge; returns at the next negedge
  task automatic strobe(input logic dc, input logic mio, input logic wr, input logic ads,
                        input logic [7:0] be, input logic [31:0] baddr);
    ads_i = ads; dc_i = dc; mio_i = mio; wr_i = wr; be_i = be; addr_i = baddr[31:3];
    @(negedge clk);
    drive_idle();
  endtask

  task automatic t_reset_state();
    check("R10", "rdy after reset", 64'(rdy_o), 64'h0);
    check("R10", "type after reset", 64'(type_o), 64'h0);
    check("R10", "valid after reset", 64'(trace_valid_o), 64'h0);
    check("R10", "src after reset", 64'(trace_src_o), 64'h0);
    check("R10", "tgt after reset", 64'(trace_tgt_o), 64'h0);
  endtask

  task automatic single_cycle(input string req, input logic [7:0] be, input logic [31:0] baddr);
    strobe(1'b0, 1'b0, 1'b1, 1'b1, be, baddr);
    check(req, "ready one clock after strobe", 64'(rdy_o), 64'h1);
    check(req, "type flag", 64'(type_o), 64'(expect_type(be, baddr)));
    @(negedge clk);
    check("R6", "ready drops after one clock", 64'(rdy_o), 64'h0);
    check("R6", "flag lasts one clock", 64'(type_o), 64'h0);
  endtask

  task automatic t_map();
    single_cycle("R2", 8'hFE, 32'h0);
    single_cycle("R2", 8'hFD, 32'h0);
    single_cycle("R2", 8'hF7, 32'h0);
    single_cycle("R2", 8'hEF, 32'h0);
  endtask

  task automatic t_stop_vs_halt();
    single_cycle("R3", 8'hFB, 32'h10);
    single_cycle("R3", 8'hFB, 32'h0);
    single_cycle("R3", 8'hFB, 32'h08);
  endtask

  task automatic t_unknown();
    single_cycle("R4", 8'hFF, 32'h0);
    single_cycle("R4", 8'hFE, 32'h10);
    single_cycle("R4", 8'h00, 32'hFFFF_FFF8);
  endtask

  task automatic quiet(input string what, input logic dc, input logic mio, input logic wr, input logic ads);
    strobe(dc, mio, wr, ads, 8'hFE, 32'h0);
    check("R5", what, 64'({rdy_o, type_o}), 64'h0);
    @(negedge clk);
    check("R5", what, 64'({rdy_o, type_o}), 64'h0);
  endtask

  task automatic t_not_special();
    quiet("memory read", 1'b1, 1'b1, 1'b0, 1'b1);
    quiet("io write", 1'b1, 1'b0, 1'b1, 1'b1);
    quiet("code fetch", 1'b0, 1'b1, 1'b0, 1'b1);
    quiet("special code without strobe", 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_trace(input logic [31:0] src, input logic [31:0] tgt, input logic busy_strobe);
    strobe(1'b0, 1'b0, 1'b1, 1'b1, 8'hDF, 32'h0);
    check("R7", "first ready", 64'(rdy_o), 64'h1);
    check("R2", "trace flag", 64'(type_o), 64'h40);
    data_i = src;
    if (busy_strobe) begin
      ads_i = 1'b1; dc_i = 1'b0; mio_i = 1'b0; wr_i = 1'b1; be_i = 8'hFE;
    end
    @(negedge clk);
    drive_idle();
    check("R7", "second ready", 64'(rdy_o), 64'h1);
    check("R7", "no flag in second transfer", 64'(type_o), 64'h0);
    data_i = tgt;
    @(negedge clk);
    data_i = 32'hDEAD_0000;
    check("R8", "ready drops after second transfer", 64'(rdy_o), 64'h0);
    check("R9", "no flag from busy strobe", 64'(type_o), 64'h0);
    check("R8", "valid pulse", 64'(trace_valid_o), 64'h1);
    check("R8", "source pointer", 64'(trace_src_o), 64'(src));
    check("R8", "target pointer", 64'(trace_tgt_o), 64'(tgt));
    @(negedge clk);
    check("R8", "valid lasts one clock", 64'(trace_valid_o), 64'h0);
    check("R8", "source held", 64'(trace_src_o), 64'(src));
    check("R8", "target held", 64'(trace_tgt_o), 64'(tgt));
  endtask

  task automatic t_busy_ignore();
    strobe(1'b0, 1'b0, 1'b1, 1'b1, 8'hFB, 32'h0);
    check("R9", "halt ready", 64'(rdy_o), 64'h1);
    strobe(1'b0, 1'b0, 1'b1, 1'b1, 8'hFE, 32'h0);
    check("R9", "strobe during ready gives nothing", 64'({rdy_o, type_o}), 64'h0);
    @(negedge clk);
    check("R9", "still quiet", 64'({rdy_o, type_o}), 64'h0);
  endtask

  task automatic t_back_to_back();
    strobe(1'b0, 1'b0, 1'b1, 1'b1, 8'hEF, 32'h0);
    check("R1", "first of pair", 64'(type_o), 64'h20);
    @(negedge clk);
    strobe(1'b0, 1'b0, 1'b1, 1'b1, 8'hFD, 32'h0);
    check("R1", "second of pair", 64'({rdy_o, type_o}), 64'h102);
    @(negedge clk);
  endtask

  task automatic t_reset_mid();
    strobe(1'b0, 1'b0, 1'b1, 1'b1, 8'hDF, 32'h0);
    data_i = 32'h1111_2222;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10", "ready cleared mid trace", 64'(rdy_o), 64'h0);
    check("R10", "source cleared", 64'(trace_src_o), 64'h0);
    check("R10", "target cleared", 64'(trace_tgt_o), 64'h0);
    @(negedge clk);
    check("R10", "no leftover transfer", 64'({trace_valid_o, rdy_o, type_o}), 64'h0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    drive_idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_map();
    t_stop_vs_halt();
    t_unknown();
    t_not_special();
    t_trace(32'h0040_1234, 32'h0040_8000, 1'b0);
    t_trace(32'hFFFF_FFF0, 32'h0000_0004, 1'b1);
    t_busy_ignore();
    t_back_to_back();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule